// File: doc/BRIEF.md
# Unaligned Access Split Unit

This unit sits between a core's load/store path and a data memory port that may refuse requests. It accepts one load or store at a time, given as a byte address and a size of one to eight bytes. If the bytes of the access all lie inside one cache block, it sends one request and finishes on one response. If the access runs over a block boundary, it cuts the access into a low fragment and a high fragment. It sends them in that order, holding any fragment the port refuses. It then waits for both responses and returns one merged result to the core.

Fragment data travels right-justified on the memory bus: byte lane j carries the j-th byte of the fragment, and lane j is enabled when j is less than the fragment length. Store data is captured in full when the access is accepted, and each fragment drives its own slice of it. For loads, each response is placed at the byte offset of its fragment inside a shared buffer. Any access that needs more than two fragments is rejected with an error and is never issued. So is a split access flagged as locked or swap.

Top module: `usplit_unit`

## Requirements
- R1: Let base be (addr + size − 1) rounded down to a multiple of BLOCK_BYTES. An access is split into two fragments exactly when base is greater than addr.
- R2: For a split access, fragment 0 has address addr and length base − addr, and fragment 1 has address base and length size − (base − addr). On every offered request, mreq_be has bit j set exactly for j < mreq_len.
- R3: An access that is not split is offered as one request with mreq_addr = addr and mreq_len = size. It completes on its single response.
- R4: An access with size 0, size above 8, or bytes in more than two blocks gets cresp_valid with cresp_err high in the cycle after acceptance. No memory request is offered for it.
- R5: An access with creq_lock high that would need splitting is rejected as in R4. A locked access that is not split is issued normally, with mreq_lock high.
- R6: While mreq_valid is high and mreq_ready is low, mreq_valid stays high and the address, length, enables and data of the request stay unchanged in the next cycle.
- R7: Fragment 1 is never offered before fragment 0 is accepted. It is offered in the cycle right after fragment 0 is accepted.
- R8: The unit counts its outstanding fragments. cresp_valid rises only in the cycle after the last expected response arrives, never earlier.
- R9: For a load, byte i of cresp_rdata equals memory byte addr + i for i < size, and all higher bytes are zero. Responses return in issue order, each carrying the fragment's bytes right-justified.
- R10: For a store, fragment 0 carries creq_wdata bytes [0, len0) in lanes 0 upward. Fragment 1 carries bytes [len0, size) in lanes 0 upward. All other lanes are zero.
- R11: creq_ready is high only while the unit is idle. cresp_valid is a single-cycle pulse, and the unit is idle again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| creq_valid | input | 1 | Core offers an access |
| creq_ready | output | 1 | Unit idle, access taken on valid |
| creq_write | input | 1 | 1 = store, 0 = load |
| creq_lock | input | 1 | Locked or swap access |
| creq_addr | input | 32 | Byte address |
| creq_size | input | 4 | Access size in bytes |
| creq_wdata | input | 64 | Store data, byte 0 in bits 7:0 |
| cresp_valid | output | 1 | Access finished (pulse) |
| cresp_err | output | 1 | Access rejected |
| cresp_rdata | output | 64 | Merged load data |
| mreq_valid | output | 1 | Fragment offered to memory |
| mreq_ready | input | 1 | Memory accepts the fragment |
| mreq_write | output | 1 | Fragment is a store |
| mreq_lock | output | 1 | Fragment belongs to a locked access |
| mreq_addr | output | 32 | Fragment start address |
| mreq_len | output | 4 | Fragment length in bytes |
| mreq_be | output | 8 | Byte enables, lane j for j < length |
| mreq_wdata | output | 64 | Fragment store data, right-justified |
| mresp_valid | input | 1 | Memory response for the oldest fragment |
| mresp_rdata | input | 64 | Response data, right-justified |

## Verification
The bench uses a 4-byte block and sweeps every start offset over six blocks, every size from 0 to 9, and both loads and stores. The locked flag, the number of refusals on each fragment and the response latency all vary with each access. This reaches the cases where fragment 0's response arrives while fragment 1 is still being refused. A unit that decremented its outstanding count wrongly would answer after the first response, with half-merged data. A unit that merged at the wrong offset would return bytes in the wrong lanes. Other faults the bench reports: a unit that changed its request while refused, a unit that jumped to fragment 1 early, and a unit that issued a three-block access or a split locked access instead of flagging it.

// File: rtl/usplit_pkg.sv
package usplit_pkg;

  localparam int UA_AW = 32;
  localparam int UA_NB = 8;
  localparam int UA_DW = 8 * UA_NB;
  localparam int UA_SW = $clog2(UA_NB) + 1;

  typedef logic [UA_AW-1:0] addr_t;
  typedef logic [UA_SW-1:0] len_t;
  typedef logic [UA_NB-1:0] be_t;
  typedef logic [UA_DW-1:0] data_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISS0,
    ST_ISS1,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } state_t;

  typedef struct packed {
    logic  split;
    addr_t a0;
    len_t  l0;
    addr_t a1;
    len_t  l1;
  } plan_t;

  // round an address down to a block multiple, block = 2**lg bytes
  function automatic addr_t blk_floor(addr_t a, int unsigned lg);
    return (a >> lg) << lg;
  endfunction

  // byte-enable mask of n low lanes
  function automatic be_t len_mask(len_t n);
    be_t m;
    m = '0;
    for (int j = 0; j < UA_NB; j++) begin
      if (j < int'(n)) m[j] = 1'b1;
    end
    return m;
  endfunction

  // data mask of n low bytes
  function automatic data_t byte_mask(len_t n);
    data_t m;
    m = '0;
    for (int j = 0; j < UA_NB; j++) begin
      if (j < int'(n)) m[8*j +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/usplit_plan.sv
module usplit_plan
  import usplit_pkg::*;
#(
  parameter int BLOCK_BYTES = 64
) (
  input  addr_t addr,
  input  len_t  size,
  input  logic  lock,
  output plan_t plan,
  output logic  bad
);

  localparam int unsigned BLK_LG = $clog2(BLOCK_BYTES);

  addr_t last_byte;
  addr_t last_base;
  addr_t first_base;
  logic  size_bad;
  logic  span_bad;
  logic  lock_bad;

  always_comb begin
    last_byte  = addr + addr_t'(size) - addr_t'(1);
    last_base  = blk_floor(last_byte, BLK_LG);
    first_base = blk_floor(addr, BLK_LG);
    plan.split = (last_base > addr);
    plan.a0    = addr;
    plan.l0    = plan.split ? len_t'(last_base - addr) : size;
    plan.a1    = last_base;
    plan.l1    = size - plan.l0;
    size_bad   = (size == '0) || (size > len_t'(UA_NB));
    span_bad   = (last_base - first_base) > addr_t'(BLOCK_BYTES);
    lock_bad   = lock && plan.split;
    bad        = size_bad || span_bad || lock_bad;
  end

endmodule

// File: rtl/usplit_ctrl.sv
module usplit_ctrl
  import usplit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       creq_valid,
  input  logic       acc_split,
  input  logic       acc_err,
  input  logic       cur_split,
  input  logic       mreq_ready,
  input  logic       mresp_valid,
  output state_t     st,
  output logic [1:0] outst,
  output logic       rsp_idx,
  output logic       ev_accept,
  output logic       ev_issue,
  output logic       ev_resp
);

  state_t nst;
  logic   last_resp;

  assign ev_accept = (st == ST_IDLE) && creq_valid;
  assign ev_issue  = ((st == ST_ISS0) || (st == ST_ISS1)) && mreq_ready;
  assign ev_resp   = mresp_valid && (outst != 2'd0);
  assign last_resp = ev_resp && (outst == 2'd1);

  always_comb begin
    nst = st;
    case (st)
      ST_IDLE: if (creq_valid) nst = acc_err ? ST_FAIL : ST_ISS0;
      ST_ISS0: if (mreq_ready) nst = cur_split ? ST_ISS1 : ST_WAIT;
      ST_ISS1: if (mreq_ready) nst = ST_WAIT;
      ST_WAIT: if (last_resp) nst = ST_DONE;
      ST_DONE: nst = ST_IDLE;
      ST_FAIL: nst = ST_IDLE;
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      outst   <= 2'd0;
      rsp_idx <= 1'b0;
    end else begin
      st <= nst;
      if (ev_accept) begin
        outst   <= acc_err ? 2'd0 : (acc_split ? 2'd2 : 2'd1);
        rsp_idx <= 1'b0;
      end else if (ev_resp) begin
        outst   <= outst - 2'd1;
        rsp_idx <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/usplit_buf.sv
module usplit_buf
  import usplit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  data_t load_data,
  input  logic  put_en,
  input  data_t put_data,
  input  len_t  put_off,
  input  len_t  put_len,
  output data_t q
);

  data_t  put_mask;
  data_t  put_bytes;
  logic [UA_SW+2:0] sh;

  always_comb begin
    sh        = {put_off, 3'b000};
    put_mask  = byte_mask(put_len) << sh;
    put_bytes = (put_data & byte_mask(put_len)) << sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_data;
    end else if (put_en) begin
      q <= (q & ~put_mask) | put_bytes;
    end
  end

endmodule

// File: rtl/usplit_unit.sv
module usplit_unit
  import usplit_pkg::*;
#(
  parameter int BLOCK_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        creq_valid,
  output logic        creq_ready,
  input  logic        creq_write,
  input  logic        creq_lock,
  input  logic [31:0] creq_addr,
  input  logic [3:0]  creq_size,
  input  logic [63:0] creq_wdata,
  output logic        cresp_valid,
  output logic        cresp_err,
  output logic [63:0] cresp_rdata,
  output logic        mreq_valid,
  input  logic        mreq_ready,
  output logic        mreq_write,
  output logic        mreq_lock,
  output logic [31:0] mreq_addr,
  output logic [3:0]  mreq_len,
  output logic [7:0]  mreq_be,
  output logic [63:0] mreq_wdata,
  input  logic        mresp_valid,
  input  logic [63:0] mresp_rdata
);

  plan_t      acc_plan;
  logic       acc_err;
  plan_t      cur;
  logic       cur_wr;
  logic       cur_lock;
  len_t       cur_size;
  state_t     st;
  logic [1:0] outst;
  logic       rsp_idx;
  logic       ev_accept;
  logic       ev_issue;
  logic       ev_resp;
  data_t      buf_q;
  len_t       frag_off;
  len_t       put_off;
  len_t       put_len;
  logic [UA_SW+2:0] frag_sh;

  usplit_plan #(.BLOCK_BYTES(BLOCK_BYTES)) u_plan (
    .addr (creq_addr),
    .size (creq_size),
    .lock (creq_lock),
    .plan (acc_plan),
    .bad  (acc_err)
  );

  usplit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .creq_valid  (creq_valid),
    .acc_split   (acc_plan.split),
    .acc_err     (acc_err),
    .cur_split   (cur.split),
    .mreq_ready  (mreq_ready),
    .mresp_valid (mresp_valid),
    .st          (st),
    .outst       (outst),
    .rsp_idx     (rsp_idx),
    .ev_accept   (ev_accept),
    .ev_issue    (ev_issue),
    .ev_resp     (ev_resp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      cur_wr   <= 1'b0;
      cur_lock <= 1'b0;
      cur_size <= '0;
    end else if (ev_accept) begin
      cur      <= acc_plan;
      cur_wr   <= creq_write;
      cur_lock <= creq_lock;
      cur_size <= creq_size;
    end
  end

  assign put_off = rsp_idx ? cur.l0 : '0;
  assign put_len = rsp_idx ? cur.l1 : cur.l0;

  usplit_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (ev_accept),
    .load_data (creq_write ? creq_wdata : '0),
    .put_en    (ev_resp && !cur_wr),
    .put_data  (mresp_rdata),
    .put_off   (put_off),
    .put_len   (put_len),
    .q         (buf_q)
  );

  assign creq_ready  = (st == ST_IDLE);
  assign cresp_valid = (st == ST_DONE) || (st == ST_FAIL);
  assign cresp_err   = (st == ST_FAIL);
  assign cresp_rdata = ((st == ST_DONE) && !cur_wr) ? (buf_q & byte_mask(cur_size)) : '0;

  assign mreq_valid = (st == ST_ISS0) || (st == ST_ISS1);
  assign mreq_write = cur_wr;
  assign mreq_lock  = cur_lock;
  assign mreq_addr  = (st == ST_ISS1) ? cur.a1 : cur.a0;
  assign mreq_len   = (st == ST_ISS1) ? cur.l1 : cur.l0;
  assign mreq_be    = len_mask(mreq_len);
  assign frag_off   = (st == ST_ISS1) ? cur.l0 : '0;
  assign frag_sh    = {frag_off, 3'b000};
  assign mreq_wdata = (buf_q >> frag_sh) & byte_mask(mreq_len);

endmodule

// File: rtl/usplit_unit_chk.sv
module usplit_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        creq_ready,
  input logic        cresp_valid,
  input logic        cresp_err,
  input logic        mreq_valid,
  input logic        mreq_ready,
  input logic [31:0] mreq_addr,
  input logic [3:0]  mreq_len,
  input logic [7:0]  mreq_be,
  input logic [63:0] mreq_wdata,
  input logic        mresp_valid,
  input logic        ev_accept,
  input logic        acc_err,
  input logic        ev_resp,
  input logic [1:0]  outst
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_len) && $stable(mreq_wdata)); // R6

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> $countones(mreq_be) == int'(mreq_len)); // R2

  AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && acc_err |=> !mreq_valid && cresp_valid && cresp_err); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    creq_ready |-> !mreq_valid && !cresp_valid); // R11

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cresp_valid |=> !cresp_valid && creq_ready); // R11

  AST_OUTST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= 2'd2); // R8

  AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mresp_valid |-> outst != 2'd0); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cresp_valid && !cresp_err |-> $past(ev_resp) && outst == 2'd0); // R8

endmodule

bind usplit_unit usplit_unit_chk u_chk (.*);

// File: tb/usplit_unit_test.sv
module usplit_unit_test;

  localparam int BLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        creq_valid = 1'b0;
  logic        creq_ready;
  logic        creq_write = 1'b0;
  logic        creq_lock = 1'b0;
  logic [31:0] creq_addr = '0;
  logic [3:0]  creq_size = '0;
  logic [63:0] creq_wdata = '0;
  logic        cresp_valid;
  logic        cresp_err;
  logic [63:0] cresp_rdata;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic        mreq_write;
  logic        mreq_lock;
  logic [31:0] mreq_addr;
  logic [3:0]  mreq_len;
  logic [7:0]  mreq_be;
  logic [63:0] mreq_wdata;
  logic        mresp_valid = 1'b0;
  logic [63:0] mresp_rdata = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  usplit_unit #(.BLOCK_BYTES(BLK)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  function automatic logic [63:0] mem_word(int a, int n);
    logic [63:0] w;
    w = '0;
    for (int j = 0; j < n; j++) w[8*j +: 8] = mb(a + j);
    return w;
  endfunction

  function automatic logic [63:0] slice(logic [63:0] d, int off, int n);
    logic [63:0] w;
    w = '0;
    for (int j = 0; j < n; j++) w[8*j +: 8] = d[8*(off+j) +: 8];
    return w;
  endfunction

  task automatic run_txn(input int a, input int sz, input bit wr, input bit lk,
                         input logic [63:0] wd, input int ref0, input int ref1, input int lat);
    int fb, lb, nblk, need, l0, l1, issued, sent, last_sent;
    int refl [2];
    int resp_at [2];
    int fa [2];
    int fl [2];
    bit experr, split, done, prev_ref, prev_acc0;
    logic [31:0] s_addr;
    logic [3:0]  s_len;
    logic [63:0] s_wd, exp_rd;
    fb = a / BLK;
    lb = (sz > 0) ? (a + sz - 1) / BLK : fb;
    nblk = lb - fb + 1;
    split = (sz >= 1) && (nblk == 2);
    experr = (sz == 0) || (sz > 8) || (nblk > 2) || (lk && split);
    need = split ? 2 : 1;
    l0 = split ? (fb + 1) * BLK - a : sz;
    l1 = sz - l0;
    fa[0] = a; fl[0] = l0; fa[1] = (fb + 1) * BLK; fl[1] = l1;
    refl[0] = ref0; refl[1] = ref1;
    resp_at[0] = -1; resp_at[1] = -1;
    issued = 0; sent = 0; last_sent = -10;
    done = 0; prev_ref = 0; prev_acc0 = 0;
    s_addr = '0; s_len = '0; s_wd = '0;

    chk(creq_ready === 1'b1, "R11 ready when idle", 64'(creq_ready), 64'd1);
    creq_valid = 1'b1; creq_write = wr; creq_lock = lk;
    creq_addr = 32'(a); creq_size = 4'(sz); creq_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    creq_valid = 1'b0;

    for (int cyc = 0; cyc < 80; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mreq_ready = 1'b0;
      mresp_valid = 1'b0;
      mresp_rdata = '0;
      if (experr) begin
        chk(cresp_valid && cresp_err && !mreq_valid, "R4/R5 rejected without issue",
            {61'd0, cresp_valid, cresp_err, mreq_valid}, 64'b110);
        done = 1;
        break;
      end
      if (cresp_valid) begin
        chk(!cresp_err, "R3 no error on legal access", 64'(cresp_err), 64'd0);
        chk(sent == need && last_sent == cyc - 1, "R8 completion after last response",
            64'(sent), 64'(need));
        exp_rd = wr ? 64'd0 : mem_word(a, sz);
        chk(cresp_rdata === exp_rd, "R9 merged load data", cresp_rdata, exp_rd);
        done = 1;
        break;
      end
      if (prev_acc0 && split)
        chk(mreq_valid === 1'b1, "R7 fragment 1 follows at once", 64'(mreq_valid), 64'd1);
      prev_acc0 = 0;
      if (prev_ref)
        chk(mreq_valid && mreq_addr == s_addr && mreq_len == s_len && mreq_wdata == s_wd,
            "R6 refused request held", 64'(mreq_addr), 64'(s_addr));
      if (mreq_valid) begin
        if (issued >= need) begin
          chk(1'b0, "R3/R7 extra fragment", 64'(issued), 64'(need));
        end else begin
          chk(mreq_addr == 32'(fa[issued]) && mreq_len == 4'(fl[issued]),
              split ? "R2 fragment address and length" : "R3 single request",
              {28'd0, mreq_len, mreq_addr}, {28'd0, 4'(fl[issued]), 32'(fa[issued])});
          chk(mreq_be == 8'((1 << fl[issued]) - 1), "R2 byte enables",
              64'(mreq_be), 64'((1 << fl[issued]) - 1));
          chk(mreq_write == wr && mreq_lock == lk, "R5 write and lock flags",
              {62'd0, mreq_write, mreq_lock}, {62'd0, wr, lk});
          if (wr)
            chk(mreq_wdata == slice(wd, issued == 0 ? 0 : l0, fl[issued]),
                "R10 store slice", mreq_wdata, slice(wd, issued == 0 ? 0 : l0, fl[issued]));
          if (refl[issued] > 0) begin
            refl[issued]--;
            prev_ref = 1;
            s_addr = mreq_addr; s_len = mreq_len; s_wd = mreq_wdata;
          end else begin
            mreq_ready = 1'b1;
            prev_ref = 0;
            resp_at[issued] = cyc + lat;
            if (issued == 0) prev_acc0 = 1;
            issued++;
          end
        end
      end else begin
        prev_ref = 0;
      end
      if (sent < issued && resp_at[sent] == cyc) begin
        mresp_valid = 1'b1;
        mresp_rdata = mem_word(fa[sent], fl[sent]);
        sent++;
        last_sent = cyc;
      end
    end
    mreq_ready = 1'b0;
    mresp_valid = 1'b0;
    if (!done) chk(1'b0, "R8 access never completed", 64'd0, 64'd1);
    @(negedge clk);
    chk(!cresp_valid && creq_ready, "R11 single pulse then idle",
        {62'd0, cresp_valid, creq_ready}, 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(creq_ready && !mreq_valid && !cresp_valid, "R11 reset state",
        {61'd0, creq_ready, mreq_valid, cresp_valid}, 64'b100);
    // R1: the sweep hits every offset within a block against every size
    for (int a = 0; a < 6 * BLK; a++) begin
      for (int sz = 0; sz <= 9; sz++) begin
        for (int wr = 0; wr < 2; wr++) begin
          run_txn(a, sz, wr[0], ((a + sz + wr) % 4) == 0,
                  64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h0101_0101_0101_0101) ^ 64'(sz << 40),
                  (a + sz) % 3, (a * sz + wr) % 3, 1 + (a % 3));
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule